// File: doc/BRIEF.md
# Rounding and Saturating Fixed-Point Multiplier

This block multiplies two signed 16-bit fixed-point operands. Both operands use the same number of fraction bits, set by the parameter `FRAC`, and the result comes back in that same format. The block forms the exact 32-bit product first. It then adds half of one result LSB and shifts right arithmetically by `FRAC` bits. Last, it clamps the value to the signed 16-bit range and raises a flag whenever the clamp changed the value.

Operands come in on a valid/ready handshake. The arithmetic is combinational, and one output register holds the result, so an accepted operand pair appears on the output one clock later. A result waits in the register while the consumer stalls, and a new pair is accepted when the register is empty or is being drained in the same cycle. Each operation stands alone: no state carries over from one result to the next.

Top module: `fxm_mul_sat`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 after that edge.
- R2: `out_data` equals the rounded and rescaled value of the full 32-bit signed product `in_a * in_b`; no bit is lost before rescaling.
- R3: The rounding adds 2^(FRAC-1) before the shift, so an exact halfway value rounds toward +infinity (with FRAC=8: 0x0180 × 0x0001 gives 0x0002, and 0xFE80 × 0x0001 gives 0xFFFF).
- R4: Rescaling is a sign-preserving right shift by FRAC bits, so negative products give correct negative results.
- R5: A rescaled value above 32767 gives `out_data` = 0x7FFF with `out_sat` = 1 (with FRAC=15: 0x8000 × 0x8000 gives 0x7FFF).
- R6: A rescaled value below -32768 gives `out_data` = 0x8000 with `out_sat` = 1.
- R7: `out_sat` is 1 only for a result that was clamped. A valid result with `out_sat` = 1 is always 0x7FFF or 0x8000, and an in-range result has `out_sat` = 0.
- R8: Saturation is not sticky. The result that follows a clamped result depends only on its own operands.
- R9: When `in_valid` and `in_ready` are both 1 at a clock edge, `out_valid` is 1 after that edge, and the result belongs to those operands.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_sat` and `out_valid` keep their values, and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 16 | First operand, two's complement, FRAC fraction bits |
| in_b | input | 16 | Second operand, same format |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Rounded, saturated product |
| out_sat | output | 1 | The result was clamped |

## Verification
The assertions check the handshake rules on every cycle: reset clearing, one-cycle latency after an accepted pair, the result holding still under back-pressure, and the stall on the input side. They also check that a saturation flag is only ever seen together with one of the two rail values. Whether a value is numerically correct can only be shown by the bench. Its scenarios cover the exact product, the direction of rounding at halfway points, negative shifts, both clamp rails and recovery right after a clamp, and it checks each of these against an independently computed integer reference at two fraction widths.

// File: rtl/fxm_pkg.sv
// fxm_pkg: shared widths and types of the fixed-point multiplier.
// Assumes 16-bit operands; the product width follows from that.
package fxm_pkg;
    localparam int DATA_W = 16;
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = PROD_W + 1;

    typedef logic signed [DATA_W-1:0] data_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef struct packed {
        data_t value;
        logic  sat;
    } result_t;
endpackage

// File: rtl/fxm_product.sv
// fxm_product: exact signed product of two operands at double width.
// Assumes two's complement inputs; purely combinational.
module fxm_product
    import fxm_pkg::*;
(
    input  data_t op_a,
    input  data_t op_b,
    output prod_t product
);
    // Full-precision signed multiply, no truncation.
    always_comb begin
        product = prod_t'(op_a) * prod_t'(op_b);
    end
endmodule

// File: rtl/fxm_rescale.sv
// fxm_rescale: adds the half-LSB rounding term, shifts right by FRAC with
// sign, and clamps to the 16-bit signed range, flagging any clamp.
// Assumes 1 <= FRAC <= DATA_W-1; works one bit wider than the product so
// the rounding add can never wrap.
module fxm_rescale
    import fxm_pkg::*;
#(
    parameter int FRAC = 8
) (
    input  prod_t   product,
    output result_t res
);
    localparam logic signed [EXT_W-1:0] HALF_LSB = EXT_W'(1) << (FRAC - 1);
    localparam logic signed [EXT_W-1:0] TOP_REP  =
        {{(EXT_W-DATA_W){1'b0}}, {1'b0, {(DATA_W-1){1'b1}}}};
    localparam logic signed [EXT_W-1:0] BOT_REP  =
        {{(EXT_W-DATA_W){1'b1}}, {1'b1, {(DATA_W-1){1'b0}}}};

    logic signed [EXT_W-1:0] widened;
    logic signed [EXT_W-1:0] rounded;
    logic signed [EXT_W-1:0] shifted;

    // Round half toward +infinity, then shift keeping the sign.
    always_comb begin
        widened = {product[PROD_W-1], product};
        rounded = widened + HALF_LSB;
        shifted = rounded >>> FRAC;
    end

    // Clamp to the representable range and report it.
    always_comb begin
        if (shifted > TOP_REP) begin
            res.value = TOP_REP[DATA_W-1:0];
            res.sat   = 1'b1;
        end else if (shifted < BOT_REP) begin
            res.value = BOT_REP[DATA_W-1:0];
            res.sat   = 1'b1;
        end else begin
            res.value = shifted[DATA_W-1:0];
            res.sat   = 1'b0;
        end
    end
endmodule

// File: rtl/fxm_outreg.sv
// fxm_outreg: one-entry result register with a valid/ready handshake.
// It accepts new data when empty or when being drained in the same cycle.
// Synchronous active-low reset clears only the valid bit.
module fxm_outreg
    import fxm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_valid,
    output logic    load_ready,
    input  result_t load_data,
    output logic    hold_valid,
    input  logic    take_ready,
    output result_t hold_data
);
    // Free slot when empty or when the current entry leaves now.
    always_comb begin
        load_ready = !hold_valid || take_ready;
    end

    // Track whether the register holds an untaken result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
        end else if (load_ready) begin
            hold_valid <= load_valid;
        end
    end

    // Capture the result on an accepted transfer.
    always_ff @(posedge clk) begin
        if (load_valid && load_ready) begin
            hold_data <= load_data;
        end
    end

    p_hold_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid && !take_ready |=> hold_valid && $stable(hold_data));

    p_accept_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && load_ready |=> hold_valid);
endmodule

// File: rtl/fxm_mul_sat.sv
// fxm_mul_sat: rounding, saturating multiplier for signed 16-bit fixed-point
// operands with FRAC fraction bits. Latency is one clock from acceptance.
// Assumes 1 <= FRAC <= 15 and that both operands share the same format.
module fxm_mul_sat
    import fxm_pkg::*;
#(
    parameter int FRAC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sat
);
    prod_t   product;
    result_t next_res;
    result_t held_res;

    fxm_product u_product (
        .op_a    (data_t'(in_a)),
        .op_b    (data_t'(in_b)),
        .product (product)
    );

    fxm_rescale #(.FRAC(FRAC)) u_rescale (
        .product (product),
        .res     (next_res)
    );

    fxm_outreg u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .load_data  (next_res),
        .hold_valid (out_valid),
        .take_ready (out_ready),
        .hold_data  (held_res)
    );

    // Unpack the held result onto the output ports.
    always_comb begin
        out_data = held_res.value;
        out_sat  = held_res.sat;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_sat_on_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sat |-> (out_data == 16'h7FFF || out_data == 16'h8000));

    p_stall_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/sim_fxm_mul_sat.sv
module sim_fxm_mul_sat;
    localparam int CLK_PERIOD = 10;
    localparam int Q_LO = 8;
    localparam int Q_HI = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_ready = 1'b1;
    logic        rdy0, rdy1, ov0, ov1, sat0, sat1;
    logic [15:0] res0, res1;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxm_mul_sat #(.FRAC(Q_LO)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
        .in_a(in_a), .in_b(in_b), .out_valid(ov0), .out_ready(out_ready),
        .out_data(res0), .out_sat(sat0));

    fxm_mul_sat #(.FRAC(Q_HI)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
        .in_a(in_a), .in_b(in_b), .out_valid(ov1), .out_ready(out_ready),
        .out_data(res1), .out_sat(sat1));

    function automatic logic [16:0] model(input logic [15:0] a,
                                          input logic [15:0] b, input int q);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        p = p + (longint'(1) << (q - 1));
        p = p >>> q;
        if (p > 32767)  return {1'b1, 16'h7FFF};
        if (p < -32768) return {1'b1, 16'h8000};
        return {1'b0, p[15:0]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one pair, then compare both widths one clock later.
    task automatic op(input logic [15:0] a, input logic [15:0] b, input string req);
        logic [16:0] e0, e1;
        @(negedge clk);
        in_a = a; in_b = b; in_valid = 1'b1;
        check(rdy0 && rdy1, {req, " R9 ready"}, {30'd0, rdy0, rdy1}, 32'd3);
        @(negedge clk);
        in_valid = 1'b0;
        e0 = model(a, b, Q_LO);
        e1 = model(a, b, Q_HI);
        check(ov0 && ov1, {req, " R9 valid"}, {30'd0, ov0, ov1}, 32'd3);
        check({sat0, res0} == e0, {req, " q8"}, {15'd0, sat0, res0}, {15'd0, e0});
        check({sat1, res1} == e1, {req, " q15"}, {15'd0, sat1, res1}, {15'd0, e1});
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ov0 && !ov1, "R1 reset", {30'd0, ov0, ov1}, 32'd0);
        rst_n = 1'b1;

        op(16'h0300, 16'h0200, "R2 3*2");
        op(16'h1234, 16'h0567, "R2 exact");
        op(16'h0180, 16'h0001, "R3 half pos");
        op(16'hFE80, 16'h0001, "R3 half neg");
        op(16'h0080, 16'h0001, "R3 half small");
        op(16'hFD00, 16'h0200, "R4 neg*pos");
        op(16'h0300, 16'hFE00, "R4 pos*neg");
        op(16'hFD00, 16'hFE00, "R4 neg*neg");
        op(16'h8000, 16'h8000, "R5 min*min");
        op(16'h7FFF, 16'h7FFF, "R5 max*max");
        op(16'h7FFF, 16'h8000, "R6 max*min");
        op(16'h4000, 16'hC000, "R6 neg clamp");
        op(16'h0100, 16'h0100, "R8 after clamp");
        op(16'h0000, 16'h8000, "R7 zero");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 4 == 1) rb = -rb;
            if (i % 8 == 3) ra = {ra[15], ra[15], ra[15], ra[12:0]};
            op(ra, rb, "R2 random");
        end

        // Back-pressure: hold the result while the consumer stalls.
        @(negedge clk);
        out_ready = 1'b0;
        in_a = 16'h0200; in_b = 16'h0300; in_valid = 1'b1;
        @(negedge clk);
        in_a = 16'h0700; in_b = 16'h0100;
        check(!rdy0 && !rdy1, "R10 stall ready", {30'd0, rdy0, rdy1}, 32'd0);
        @(negedge clk);
        check(ov0 && res0 == 16'h0600, "R10 hold", {15'd0, ov0, res0}, {15'd1, 16'h0600});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(ov0 && res0 == 16'h0700, "R10 release", {15'd0, ov0, res0}, {15'd1, 16'h0700});
        @(negedge clk);
        check(!ov0, "R9 drained", {31'd0, ov0}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule